// File: doc/BRIEF.md
# Line-Bundle Instruction Consumer

This block sits on the decode side of a fetch queue. Fetch delivers whole cache lines as bundles, each tagged with a fetch generation and a PC. The consumer keeps its own architectural PC and generation. It looks at the bundle at the queue head without removing it. It takes the instruction word that the low bits of its PC select, and it passes that word to execution. It then waits for execution to return the next PC before it issues again.

A bundle is removed only when control flow leaves its line. That happens when the next PC falls in another line, or when the bundle belongs to the wrong line altogether. In the second case the consumer steps its generation and sends a restart to fetch, carrying the new generation and the PC it wants. Bundles from an older generation are left alone, because the restart that follows will flush them. A halt input freezes consumption while no instruction is in flight.

Top module: `line_bundle_consumer`

## Requirements
- R1: During and right after reset, instValid, restartValid and bundleDiscard are low. The PC starts at RESET_PC and the generation starts at 0.
- R2: Issuing an instruction does not remove the head bundle. bundleDiscard is raised only in the cases R5 and R8 describe.
- R3: If a valid bundle's generation differs from the current generation, it issues nothing, is not discarded and causes no restart.
- R4: A bundle matches when its line address (PC shifted right by log2 LINE_WORDS) equals that of the current PC. On a match, instValid is high for the next cycle only. instPc is the current PC, and instWord is the data word at offset PC mod LINE_WORDS. Word k sits at bits k*WORD_W and up.
- R5: If the generations match but the line addresses differ, bundleDiscard is high in that cycle and nothing issues. In the next cycle restartValid is high, restartGen equals the old generation plus one (modulo 2^GEN_W), and restartPc equals the current PC.
- R6: restartValid lasts one cycle. No bundle is evaluated in a cycle where restartValid is high.
- R7: After an issue, no further instruction issues until nextPcValid is seen.
- R8: When nextPcValid arrives while an instruction is in flight, the PC takes nextPc. bundleDiscard is high in that cycle exactly when nextPc lies in a different line from the old PC.
- R9: While halted is high and nothing is in flight, no instruction issues, no bundle is discarded and no restart is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| halted | input | 1 | Stop taking new bundles while idle |
| bundleValid | input | 1 | Head of fetch queue present |
| bundleGen | input | GEN_W | Generation tag of head bundle |
| bundlePc | input | PC_W | PC of head bundle |
| bundleData | input | LINE_WORDS*WORD_W | Line words, word k at bits k*WORD_W |
| bundleDiscard | output | 1 | Pop the head bundle this cycle |
| instValid | output | 1 | Instruction word valid (one cycle) |
| instPc | output | PC_W | PC of issued instruction |
| instWord | output | WORD_W | Issued instruction word |
| nextPcValid | input | 1 | Execution reports next PC |
| nextPc | input | PC_W | Next architectural PC |
| restartValid | output | 1 | Fetch restart request (one cycle) |
| restartGen | output | GEN_W | New fetch generation |
| restartPc | output | PC_W | PC fetch must restart at |

## Verification
A behavioural model of the consumer and of a sequential fetch unit runs next to the design and is compared with it every cycle. Sequential next PCs, including the wrap at the top of the PC space, check in-line word selection and line-exit discards. Jumps that stay inside a line show that a bundle is kept across many issues. Far jumps make the prefetched line stale, which brings out the redirect, the generation step and the single-cycle restart. Halt windows and forced wrong-generation tags show that nothing is consumed, issued or restarted in those cycles.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef struct packed {
    logic issue;
    logic redirect;
    logic complete;
    logic discard;
  } lbcStrobes_t;
endpackage

// File: rtl/lbc_ctrl.sv
module lbc_ctrl
  import lbc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        halted,
  input  logic        bundleValid,
  input  logic        nextPcValid,
  input  logic        genMatch,
  input  logic        lineMatch,
  input  logic        nextLineDiff,
  input  logic        restartValid,
  output logic        waitExec,
  output lbcStrobes_t st
);
  logic evaluate;

  always_comb begin
    evaluate    = !waitExec && !halted && bundleValid && !restartValid && genMatch;
    st.issue    = evaluate && lineMatch;
    st.redirect = evaluate && !lineMatch;
    st.complete = waitExec && nextPcValid;
    st.discard  = st.redirect || (st.complete && nextLineDiff);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            waitExec <= 1'b0;
    else if (st.issue)    waitExec <= 1'b1;
    else if (st.complete) waitExec <= 1'b0;
  end

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !waitExec) |-> (!st.discard && !st.issue && !st.redirect));

  p_no_eval_in_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    restartValid |-> (!st.issue && !st.redirect));

  p_single_inflight_r7: assert property (@(posedge clk) disable iff (!rstN)
    (waitExec && !nextPcValid) |=> !st.issue);
endmodule

// File: rtl/lbc_datapath.sv
module lbc_datapath
  import lbc_pkg::*;
#(
  parameter int PC_W       = 12,
  parameter int WORD_W     = 12,
  parameter int LINE_WORDS = 8,
  parameter int GEN_W      = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  lbcStrobes_t                  st,
  input  logic [GEN_W-1:0]             bundleGen,
  input  logic [PC_W-1:0]              bundlePc,
  input  logic [LINE_WORDS*WORD_W-1:0] bundleData,
  input  logic [PC_W-1:0]              nextPc,
  output logic                         genMatch,
  output logic                         lineMatch,
  output logic                         nextLineDiff,
  output logic                         instValid,
  output logic [PC_W-1:0]              instPc,
  output logic [WORD_W-1:0]            instWord,
  output logic                         restartValid,
  output logic [GEN_W-1:0]             restartGen,
  output logic [PC_W-1:0]              restartPc
);
  localparam int OFF_W = $clog2(LINE_WORDS);

  logic [PC_W-1:0]   pc;
  logic [GEN_W-1:0]  gen;
  logic [WORD_W-1:0] lineWords [LINE_WORDS];
  logic [WORD_W-1:0] pickedWord;

  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_unpack
    assign lineWords[k] = bundleData[k*WORD_W +: WORD_W];
  end

  always_comb begin
    pickedWord   = lineWords[pc[OFF_W-1:0]];
    genMatch     = (bundleGen == gen);
    lineMatch    = (bundlePc[PC_W-1:OFF_W] == pc[PC_W-1:OFF_W]);
    nextLineDiff = (nextPc[PC_W-1:OFF_W] != pc[PC_W-1:OFF_W]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc           <= RESET_PC;
      gen          <= '0;
      instValid    <= 1'b0;
      instPc       <= '0;
      instWord     <= '0;
      restartValid <= 1'b0;
      restartGen   <= '0;
      restartPc    <= '0;
    end else begin
      instValid    <= st.issue;
      restartValid <= st.redirect;
      if (st.issue) begin
        instPc   <= pc;
        instWord <= pickedWord;
      end
      if (st.redirect) begin
        gen        <= gen + 1'b1;
        restartGen <= gen + 1'b1;
        restartPc  <= pc;
      end
      if (st.complete) pc <= nextPc;
    end
  end

  p_restart_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    restartValid |=> !restartValid);

  p_redirect_out_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.redirect |=> (restartValid && restartPc == $past(pc)
                     && restartGen == GEN_W'($past(gen) + 1'b1)));

  p_issue_out_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.issue |=> (instValid && instPc == $past(pc)));

  p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !st.complete |=> $stable(pc));
endmodule

// File: rtl/line_bundle_consumer.sv
module line_bundle_consumer
  import lbc_pkg::*;
#(
  parameter int PC_W       = 12,
  parameter int WORD_W     = 12,
  parameter int LINE_WORDS = 8,
  parameter int GEN_W      = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         halted,
  input  logic                         bundleValid,
  input  logic [GEN_W-1:0]             bundleGen,
  input  logic [PC_W-1:0]              bundlePc,
  input  logic [LINE_WORDS*WORD_W-1:0] bundleData,
  output logic                         bundleDiscard,
  output logic                         instValid,
  output logic [PC_W-1:0]              instPc,
  output logic [WORD_W-1:0]            instWord,
  input  logic                         nextPcValid,
  input  logic [PC_W-1:0]              nextPc,
  output logic                         restartValid,
  output logic [GEN_W-1:0]             restartGen,
  output logic [PC_W-1:0]              restartPc
);
  lbcStrobes_t st;
  logic genMatch, lineMatch, nextLineDiff, waitExec;

  lbc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .halted(halted), .bundleValid(bundleValid),
    .nextPcValid(nextPcValid), .genMatch(genMatch), .lineMatch(lineMatch),
    .nextLineDiff(nextLineDiff), .restartValid(restartValid),
    .waitExec(waitExec), .st(st)
  );

  lbc_datapath #(
    .PC_W(PC_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS),
    .GEN_W(GEN_W), .RESET_PC(RESET_PC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .bundleGen(bundleGen),
    .bundlePc(bundlePc), .bundleData(bundleData), .nextPc(nextPc),
    .genMatch(genMatch), .lineMatch(lineMatch), .nextLineDiff(nextLineDiff),
    .instValid(instValid), .instPc(instPc), .instWord(instWord),
    .restartValid(restartValid), .restartGen(restartGen), .restartPc(restartPc)
  );

  assign bundleDiscard = st.discard;

  p_discard_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    instValid |-> $past(!bundleDiscard));
endmodule

// File: tb/line_bundle_consumer_tb.sv
module line_bundle_consumer_tb_top;
  localparam int PC_W = 12, WORD_W = 16, LW = 4, GEN_W = 3;
  localparam int PC_MOD = 4096, GEN_MOD = 8;
  localparam logic [PC_W-1:0] RST_PC = 12'd4088;

  logic clk = 1'b0, rstN = 1'b0;
  logic halted = 1'b0, bundleValid = 1'b0, nextPcValid = 1'b0;
  logic [GEN_W-1:0] bundleGen = '0;
  logic [PC_W-1:0]  bundlePc = '0, nextPc = '0;
  logic [LW*WORD_W-1:0] bundleData = '0;
  logic bundleDiscard, instValid, restartValid;
  logic [PC_W-1:0] instPc, restartPc;
  logic [WORD_W-1:0] instWord;
  logic [GEN_W-1:0] restartGen;

  always #5 clk = ~clk;

  line_bundle_consumer #(.PC_W(PC_W), .WORD_W(WORD_W), .LINE_WORDS(LW),
    .GEN_W(GEN_W), .RESET_PC(RST_PC)) dut_i (.*);

  int nTests = 0, nFail = 0;
  // reference model state
  int mPc, mGen, mWait, waitAge;
  int expIV = 0, expIP = 0, expIW = 0, expRV = 0, expRG = 0, expRP = 0;
  // fetch model
  int qBase[$], qGen[$];
  int fetchGen, fetchNext;
  int phase;

  function automatic int wordAt(int addr);
    return (addr * 37 + 16'h1234) & 16'hFFFF;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int nextFor(int pc, int ph);
    case (ph)
      1: return (pc - (pc % LW)) + ((pc + 3) % LW);
      2: return (pc + 37) % PC_MOD;
      default: return (pc + 1) % PC_MOD;
    endcase
  endfunction

  task automatic step(input bit haltReq, input bit stale);
    int dsc, nIV, nRV;
    string lbl;
    if (qBase.size() == 0) begin
      qBase.push_back(fetchNext); qGen.push_back(fetchGen);
      fetchNext = (fetchNext + LW) % PC_MOD;
    end
    bundleValid = 1'b1;
    bundleGen   = GEN_W'(stale ? (qGen[0] ^ 1) : qGen[0]);
    bundlePc    = PC_W'(qBase[0]);
    for (int k = 0; k < LW; k++) bundleData[k*WORD_W +: WORD_W] = WORD_W'(wordAt(qBase[0] + k));
    halted      = haltReq;
    nextPcValid = (mWait != 0) && (waitAge >= 1);
    nextPc      = PC_W'(nextFor(mPc, phase));
    #4;
    dsc = 0; nIV = 0; nRV = 0; lbl = "R2";
    if (mWait != 0) begin
      if (nextPcValid) begin
        lbl = "R8";
        dsc = ((int'(nextPc) / LW) != (mPc / LW));
      end
    end else if (haltReq) lbl = "R9";
    else if (expRV != 0) lbl = "R6";
    else if (int'(bundleGen) != mGen) lbl = "R3";
    else if ((int'(bundlePc) / LW) == (mPc / LW)) nIV = 1;
    else begin lbl = "R5"; dsc = 1; nRV = 1; end
    check(bundleDiscard == dsc, lbl, "bundleDiscard", bundleDiscard, dsc);
    check(instValid == expIV, "R7", "instValid", instValid, expIV);
    if (expIV != 0) begin
      check(instPc == expIP, "R4", "instPc", instPc, expIP);
      check(instWord == expIW, "R4", "instWord", instWord, expIW);
    end
    check(restartValid == expRV, "R6", "restartValid", restartValid, expRV);
    if (expRV != 0) begin
      check(restartGen == expRG, "R5", "restartGen", restartGen, expRG);
      check(restartPc == expRP, "R5", "restartPc", restartPc, expRP);
    end
    if (dsc != 0) begin void'(qBase.pop_front()); void'(qGen.pop_front()); end
    if (expRV != 0) begin
      qBase.delete(); qGen.delete();
      fetchGen = expRG; fetchNext = expRP - (expRP % LW);
    end
    // next-state of model
    expIV = nIV; expRV = nRV;
    if (nIV != 0) begin
      expIP = mPc; expIW = wordAt(int'(bundlePc) + (mPc % LW));
      mWait = 1; waitAge = 0;
    end else if (mWait != 0) begin
      if (nextPcValid) begin mPc = int'(nextPc); mWait = 0; end
      else waitAge++;
    end
    if (nRV != 0) begin
      mGen = (mGen + 1) % GEN_MOD; expRG = mGen; expRP = mPc;
    end
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    mPc = int'(RST_PC); mGen = 0; mWait = 0; waitAge = 0;
    fetchGen = 0; fetchNext = int'(RST_PC) - (int'(RST_PC) % LW);
    phase = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet while in reset
    check(instValid == 0 && restartValid == 0 && bundleDiscard == 0,
          "R1", "reset outputs", {instValid, restartValid, bundleDiscard}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(instValid == 0 && restartValid == 0, "R1", "post-reset outputs",
          {instValid, restartValid}, 0);
    phase = 0; repeat (200) step(1'b0, 1'b0);           // sequential, wraps
    phase = 1; repeat (150) step(1'b0, 1'b0);           // in-line jumps
    phase = 2; repeat (300) step(1'b0, 1'b0);           // far jumps, redirects
    phase = 0;
    for (int i = 0; i < 200; i++) step((i % 7) < 3, 1'b0); // halt windows
    for (int i = 0; i < 200; i++) step(1'b0, (i % 5) < 2); // stale gens
    phase = 2;
    for (int i = 0; i < 200; i++) step((i % 9) == 0, (i % 11) == 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule